// File: doc/BRIEF.md
# Serial EEPROM Word Read Master

This block fetches one 16-bit word from a three-wire serial EEPROM. A single-cycle `start` with a word address begins a read. The block then drives chip select, the serial clock and the serial data line. It shifts out a read command, clocks in sixteen data bits and returns the word in `rdata`, marked by a one-cycle `done` pulse. Every line change is paced by a timing unit of `UNIT_CYCLES` system clocks. The address width is an elaboration parameter.

A second entry, `mac_start`, reads the words at addresses 0, 1 and 2 in turn and packs them into a 48-bit station address. The block is meant to run once after reset to recover configuration data stored in the EEPROM.

Top module: `eeprom_word_reader`

## Requirements
- R1: The command is exactly ADDR_BITS+3 bits, sent most significant bit first. Its top three bits are the read opcode 1,1,0 and the rest is the word address, so the command value is (6 << ADDR_BITS) | address.
- R2: Chip select, clock and data-in are all low whenever the block is idle. When chip select rises, clock and data-in are low, and they have been low since at least the previous cycle. The clock is only ever high while chip select is high.
- R3: Each command bit takes three timing units: data-in is set with the clock low, then the clock is high, then the clock is low. Data-in does not change while the clock stays high.
- R4: The data phase gives sixteen clock pulses with data-in held low. Each bit is sampled at the end of its clock-high unit. The first bit sampled becomes rdata[15]. Chip select falls after exactly ADDR_BITS+19 rising clock edges.
- R5: After the last data bit, chip select is low for one timing unit before completion. From the clock edge that accepts `start` to the edge that raises `done` is exactly (3*ADDR_BITS+43)*UNIT_CYCLES cycles.
- R6: `done` is high for exactly one cycle. `busy` is high from the edge that accepts a read until the edge that raises `done`, and low from that edge on. After reset, `busy`, `done`, `mac_done`, `rdata` and `mac_addr` are all zero.
- R7: `start` and `mac_start` are ignored while `busy` is high. No extra EEPROM transaction occurs and the result is unchanged.
- R8: `rdata` changes only on the edge that raises `done`. A station-address read leaves `rdata` unchanged.
- R9: `mac_start` reads addresses 0, 1 and 2 in that order, back to back, in 3*(3*ADDR_BITS+43)*UNIT_CYCLES cycles. It ends with a one-cycle `mac_done` pulse and no `done` pulse. The result is mac_addr = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]}, so each word gives its low byte first.
- R10: If `start` and `mac_start` are both high in the same idle cycle, the station-address read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a single-word read |
| addr | input | ADDR_BITS | Word address for a single read |
| mac_start | input | 1 | Begin the three-word station-address read |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse: single read complete |
| rdata | output | 16 | Last word returned by a single read |
| mac_done | output | 1 | One-cycle pulse: station address complete |
| mac_addr | output | 48 | Assembled station address |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench reads every address of the default 6-bit configuration. Each word is computed in the bench, and the pattern includes the all-ones and all-zeros words, so a bit-order slip or an off-by-one in the data shift shows up as a wrong `rdata`. The serial responder decodes the command and counts clock edges per transaction. This catches a wrong opcode, a command one bit short or long, or a data-in line left high in the data phase. An exact cycle count for both read kinds exposes any lost or extra timing unit. Start pulses sent mid-transaction, and a simultaneous start on both entries, check that a busy block does not launch a second transaction and that the station-address path takes precedence. If it did not, the responder would see extra addresses or the result would be wrong.

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int ADDR_BITS   = 6,
  parameter int UNIT_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 mac_start,
  output logic                 busy,
  output logic                 done,
  output logic [15:0]          rdata,
  output logic                 mac_done,
  output logic [47:0]          mac_addr,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do
);
  localparam int CMD_BITS = ADDR_BITS + 3;
  localparam int CNT_W    = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam int MAX_BITS = (CMD_BITS > 16) ? CMD_BITS : 16;
  localparam int BIT_W    = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] UNIT_LAST = CNT_W'(UNIT_CYCLES - 1);
  localparam logic [BIT_W-1:0] CMD_TOP   = BIT_W'(CMD_BITS - 1);
  localparam logic [BIT_W-1:0] DAT_TOP   = BIT_W'(15);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CMD, S_DAT, S_END} state_t;

  state_t               st;
  logic [CNT_W-1:0]     div;
  logic [BIT_W-1:0]     bidx;
  logic [1:0]           sub;
  logic [ADDR_BITS-1:0] cur;
  logic [15:0]          shreg;
  logic                 mac_mode;
  logic [1:0]           widx;
  logic [31:0]          mac_acc;

  logic                 tick;
  logic [CMD_BITS-1:0]  cmd;
  logic [15:0]          swapped;

  assign busy    = (st != S_IDLE);
  assign tick    = busy && (div == UNIT_LAST);
  assign cmd     = {3'b110, cur};
  assign swapped = {shreg[7:0], shreg[15:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      bidx     <= '0;
      sub      <= '0;
      cur      <= '0;
      shreg    <= '0;
      mac_mode <= 1'b0;
      widx     <= '0;
      mac_acc  <= '0;
      done     <= 1'b0;
      mac_done <= 1'b0;
      rdata    <= '0;
      mac_addr <= '0;
      ee_cs    <= 1'b0;
      ee_sk    <= 1'b0;
      ee_di    <= 1'b0;
    end else begin
      done     <= 1'b0;
      mac_done <= 1'b0;
      if (busy) div <= tick ? '0 : div + 1'b1;
      case (st)
        S_IDLE: if (start || mac_start) begin
          st       <= S_PRE;
          div      <= '0;
          mac_mode <= mac_start;
          widx     <= '0;
          cur      <= mac_start ? '0 : addr;
          ee_cs    <= 1'b0;
          ee_sk    <= 1'b0;
          ee_di    <= 1'b0;
        end
        S_PRE: if (tick) begin
          st    <= S_CMD;
          bidx  <= CMD_TOP;
          sub   <= 2'd0;
          ee_cs <= 1'b1;
          ee_di <= cmd[CMD_BITS-1];
        end
        S_CMD: if (tick) begin
          case (sub)
            2'd0: begin sub <= 2'd1; ee_sk <= 1'b1; end
            2'd1: begin sub <= 2'd2; ee_sk <= 1'b0; end
            default: begin
              sub <= 2'd0;
              if (bidx == '0) begin
                st    <= S_DAT;
                bidx  <= DAT_TOP;
                ee_di <= 1'b0;
                ee_sk <= 1'b1;
              end else begin
                bidx  <= bidx - 1'b1;
                ee_di <= cmd[bidx-1'b1];
              end
            end
          endcase
        end
        S_DAT: if (tick) begin
          if (sub == 2'd0) begin
            shreg <= {shreg[14:0], ee_do};
            ee_sk <= 1'b0;
            sub   <= 2'd1;
          end else if (bidx == '0) begin
            st    <= S_END;
            ee_cs <= 1'b0;
          end else begin
            bidx  <= bidx - 1'b1;
            sub   <= 2'd0;
            ee_sk <= 1'b1;
          end
        end
        S_END: if (tick) begin
          if (!mac_mode) begin
            rdata <= shreg;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else if (widx == 2'd2) begin
            mac_addr <= {mac_acc, swapped};
            mac_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            mac_acc <= {mac_acc[15:0], swapped};
            widx    <= widx + 1'b1;
            cur     <= cur + 1'b1;
            st      <= S_PRE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_word_reader_chk.sv
module eeprom_word_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mac_done,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic [15:0] rdata
);
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di)); // R2
  AST_CLOCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R2
  AST_DI_STEADY_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R3
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata)); // R8
  AST_MAC_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_done |=> !mac_done); // R9
  AST_DONES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && mac_done)); // R9
endmodule

bind eeprom_word_reader eeprom_word_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mac_done(mac_done),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .rdata(rdata)
);

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;
  localparam int A          = 6;
  localparam int U          = 3;
  localparam int N          = 3 * A + 43;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [A-1:0] addr = '0;
  logic         mac_start = 1'b0;
  logic         busy, done, mac_done, ee_cs, ee_sk, ee_di;
  logic         ee_do = 1'b0;
  logic [15:0]  rdata;
  logic [47:0]  mac_addr;

  int vectors = 0;
  int miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_word_reader #(.ADDR_BITS(A), .UNIT_CYCLES(U)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .mac_start(mac_start),
    .busy(busy), .done(done), .rdata(rdata), .mac_done(mac_done), .mac_addr(mac_addr),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] wv(input int a);
    if (a == 1) return 16'h0000;
    return 16'(a * 16'h3B1D) ^ 16'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial responder, sampled away from the active edge
  logic [A+2:0]   rsp_cmd = '0;
  logic [15:0]    rsp_word = '0;
  logic [3*A-1:0] rsp_hist = '0;
  int rsp_bits = 0;
  int rsp_xact = 0;
  logic p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !p_cs) begin
        chk(!p_sk && !p_di && !ee_sk, "R2 lines low at select", {p_sk, p_di, ee_sk}, 0);
        rsp_bits = 0;
      end
      if (ee_cs && ee_sk && !p_sk) begin
        if (rsp_bits < A + 3) begin
          rsp_cmd = {rsp_cmd[A+1:0], ee_di};
          rsp_bits++;
          if (rsp_bits == A + 3) begin
            chk(rsp_cmd[A+2:A] == 3'b110, "R1 opcode", rsp_cmd[A+2:A], 3'b110);
            rsp_word = wv(int'(rsp_cmd[A-1:0]));
            rsp_hist = {rsp_hist[2*A-1:0], rsp_cmd[A-1:0]};
            rsp_xact++;
          end
        end else begin
          chk(!ee_di, "R4 data-in low in data phase", ee_di, 0);
          ee_do = rsp_word[15];
          rsp_word = {rsp_word[14:0], 1'b0};
          rsp_bits++;
        end
      end
      if (!ee_cs && p_cs)
        chk(rsp_bits == A + 19, "R4 clock edges per transaction", rsp_bits, A + 19);
    end
    p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
  end

  task automatic run_single(input int a, input bit poke);
    int k = 0;
    int x0 = rsp_xact;
    bit busy_ok = 1'b1;
    @(negedge clk); start = 1'b1; addr = A'(a);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    do begin
      @(posedge clk); k++; #1;
      if (!done && !busy) busy_ok = 1'b0;
      if (poke && k == 10) begin start = 1'b1; mac_start = 1'b1; addr = ~A'(a); end
      if (poke && k == 11) begin start = 1'b0; mac_start = 1'b0; end
    end while (!done && k < 20000);
    chk(rdata == wv(a), "R4 rdata", rdata, wv(a));
    chk(k == N * U, "R5 latency", k, N * U);
    chk(busy_ok && !busy, "R6 busy span", {busy_ok, busy}, 2'b10);
    chk(rsp_hist[A-1:0] == A'(a), "R1 address sent", rsp_hist[A-1:0], a);
    chk(rsp_xact == x0 + 1, poke ? "R7 start ignored while busy" : "R1 one transaction", rsp_xact - x0, 1);
    @(posedge clk); #1;
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  task automatic run_mac(input bit both);
    int k = 0;
    int x0 = rsp_xact;
    bit saw_done = 1'b0;
    logic [15:0] r0 = rdata;
    logic [47:0] expv = {wv(0)[7:0], wv(0)[15:8], wv(1)[7:0], wv(1)[15:8], wv(2)[7:0], wv(2)[15:8]};
    @(negedge clk); mac_start = 1'b1; start = both; addr = A'(9);
    @(posedge clk);
    @(negedge clk); mac_start = 1'b0; start = 1'b0;
    do begin
      @(posedge clk); k++; #1;
      if (done) saw_done = 1'b1;
      if (k == 100) start = 1'b1;
      if (k == 101) start = 1'b0;
    end while (!mac_done && k < 20000);
    chk(mac_addr == expv, both ? "R10 station address wins" : "R9 station address", mac_addr, expv);
    chk(k == 3 * N * U, "R9 latency", k, 3 * N * U);
    chk(!saw_done, "R9 no done pulse", saw_done, 0);
    chk(rdata == r0, "R8 rdata untouched", rdata, r0);
    chk(rsp_xact == x0 + 3, "R7 three transactions only", rsp_xact - x0, 3);
    chk(rsp_hist == {A'(0), A'(1), A'(2)}, "R9 address order", rsp_hist, {A'(0), A'(1), A'(2)});
    @(posedge clk); #1;
    chk(!mac_done, "R9 mac_done one cycle", mac_done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miss++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!busy && !done && !mac_done, "R6 reset flags", {busy, done, mac_done}, 0);
    chk(rdata == 16'h0 && mac_addr == 48'h0, "R6 reset data", {rdata, mac_addr}, 0);
    chk(!ee_cs && !ee_sk && !ee_di, "R2 reset lines", {ee_cs, ee_sk, ee_di}, 0);
    for (int a = 0; a < (1 << A); a++) run_single(a, (a == 5) || (a == 40));
    run_mac(1'b0);
    run_single(33, 1'b0);
    run_mac(1'b1);
    repeat (5) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule